// File: doc/BRIEF.md
# Burst Write Gathering Controller

The block sits between a host that produces cache-line writes and a DRAM command port. Instead of forwarding each line as it arrives, it collects a programmed number of lines in a local line buffer and then releases them to the DRAM side as one unbroken burst. Software controls it through a small control register: a gather-limit field and a flush bit. The limit field is encoded as the maximum burst size (32 lines) minus the wanted line count, so a smaller field value asks for a longer burst. The value 31 switches gathering off, and each host write is then forwarded in the same cycle.

The flush bit forces every held line out even if the limit has not been reached. It reads back as 1 until every write accepted before it has left on the DRAM port, and then clears by itself. Host writes are stalled while a burst drains or a flush is pending, so no line is dropped or reordered. Both ports use valid/ready handshakes. Each host beat carries a line address, which counts in units of 64 bytes. The DRAM port gives the byte address of each line.

Top module: `wr_gather`

## Requirements
- R1: After reset the limit readback `limit_rd` is 31, `flush_rd` is 0 and `dram_valid` is 0.
- R2: With limit field L in 0..30 and no flush, the block holds lines until it has 32-L of them. `dram_valid` stays 0 until then. It rises in the cycle after the edge where the (32-L)-th line is accepted.
- R3: Once a burst starts, `dram_valid` stays 1 in every cycle until the beat marked last is accepted. Address and data are stable while `dram_ready` is 0.
- R4: Lines leave in the order they were accepted. `dram_addr` equals the host line address times 64, with bits [5:0] zero, and `dram_data` equals the host data.
- R5: `dram_last` is 1 on the final line of each burst. In pass-through mode it is 1 on every line.
- R6: With L = 31, an empty buffer and no flush pending, each host beat is forwarded combinationally: `dram_valid` equals `host_valid` and `host_ready` equals `dram_ready` in the same cycle.
- R7: A register write with `cfg_flush`=1 sets the flush bit. On the next edge it starts a burst of all held lines, even if fewer than 32-L are held. Writing `cfg_flush`=0 leaves the flush bit unchanged.
- R8: `flush_rd` stays 1 until the edge at which the last held line is accepted on the DRAM port, and reads 0 after it. If nothing is held, it clears one cycle after being set. A set and a clear in the same cycle leave it set.
- R9: `host_ready` is 0 while a burst drains, while a flush is pending, and while the buffer holds 32-L lines.
- R10: With L = 0 a single burst carries 32 lines, and the held count never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_limit | input | 5 | Limit field value to write (32 minus wanted line count; 31 = no gathering) |
| cfg_flush | input | 1 | Flush bit value to write (1 sets, 0 no effect) |
| limit_rd | output | 5 | Current limit field |
| flush_rd | output | 1 | Flush bit readback, 1 while held lines remain |
| host_valid | input | 1 | Host write valid |
| host_ready | output | 1 | Host write accepted this cycle when both high |
| host_line | input | 26 | Host line address (byte address / 64) |
| host_data | input | 32 | Host line payload |
| dram_valid | output | 1 | DRAM write beat valid |
| dram_ready | input | 1 | DRAM side accepts the beat |
| dram_addr | output | 32 | Byte address of the line, 64-byte aligned |
| dram_data | output | 32 | Line payload |
| dram_last | output | 1 | Final line of the burst |

## Verification
`host_ready` and the pass-through path respond in the same cycle as their inputs. A burst's first beat appears one edge after the line that completes the gather, or one edge after the flush bit is seen set. Register and flush readbacks move one edge after the write or after the final beat's handshake. The bench drives inputs on the falling edge and compares every output 1 ns later against a queue-based model. The model advances once per cycle, exactly as the rising edge will, so each result is checked in the cycle it is due and never sooner.

// File: rtl/wr_gather_pkg.sv
package wr_gather_pkg;

  // Sequencer phases: collecting lines from the host or draining them out.
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_DRAIN   = 1'b1
  } gather_st_e;

endpackage

// File: rtl/wr_gather_cfg.sv
module wr_gather_cfg #(
  parameter int LIM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             cfg_flush,
  input  logic             flush_clr,
  output logic [LIM_W-1:0] limit_q,
  output logic             flush_q
);

  localparam logic [LIM_W-1:0] LIM_RST = {LIM_W{1'b1}};

  logic [LIM_W-1:0] limit_d;
  logic             flush_d;
  logic             reg_en;

  // Setting the flush bit wins over a clear in the same cycle.
  always_comb begin
    limit_d = limit_q;
    flush_d = flush_q;
    if (flush_clr) flush_d = 1'b0;
    if (cfg_we) begin
      limit_d = cfg_limit;
      if (cfg_flush) flush_d = 1'b1;
    end
  end

  assign reg_en = cfg_we | flush_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= LIM_RST;
      flush_q <= 1'b0;
    end else if (reg_en) begin
      limit_q <= limit_d;
      flush_q <= flush_d;
    end
  end

  AST_FLUSH_SET : assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_flush) |=> flush_q) else $error("flush set lost"); // R7

endmodule

// File: rtl/wr_gather_buf.sv
module wr_gather_buf #(
  parameter int DEPTH = 32,
  parameter int ENT_W = 58,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_ent
);

  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0] ent_we;

  // One write-enable per slot, decoded from the fill index.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot_we
    assign ent_we[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  // Payload storage needs no reset: a slot is read only after it is written.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_we[i]) ent_q[i] <= wr_ent;
    end
  end

  assign rd_ent = ent_q[rd_idx];

endmodule

// File: rtl/wr_gather_fsm.sv
module wr_gather_fsm
  import wr_gather_pkg::*;
#(
  parameter int MAX_LINES = 32,
  parameter int LIM_W     = 5,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] limit_q,
  input  logic             flush_q,
  input  logic             host_valid,
  input  logic             dram_ready,
  output logic             host_ready,
  output logic             buf_we,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             drain_act,
  output logic             bypass_act,
  output logic             burst_last,
  output logic             flush_clr
);

  localparam logic [LIM_W-1:0] LIM_OFF = LIM_W'(MAX_LINES - 1);

  gather_st_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_after, target;
  logic [IDX_W-1:0] rd_q, rd_d;

  // Limit field is max minus wanted count, so the target is the difference.
  assign target     = CNT_W'(MAX_LINES) - CNT_W'(limit_q);
  assign bypass_act = (limit_q == LIM_OFF) && (st_q == ST_COLLECT) &&
                      (cnt_q == '0) && !flush_q;
  assign host_ready = bypass_act ? dram_ready
                                 : ((st_q == ST_COLLECT) && !flush_q && (cnt_q < target));
  assign buf_we     = host_valid && host_ready && !bypass_act;
  assign wr_idx     = cnt_q[IDX_W-1:0];
  assign rd_idx     = rd_q;
  assign drain_act  = (st_q == ST_DRAIN);
  assign burst_last = (CNT_W'(rd_q) == (cnt_q - CNT_W'(1)));
  assign cnt_after  = cnt_q + CNT_W'(buf_we);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    rd_d      = rd_q;
    flush_clr = 1'b0;
    unique case (st_q)
      ST_COLLECT: begin
        cnt_d = cnt_after;
        if ((cnt_after != '0) && ((cnt_after >= target) || flush_q)) st_d = ST_DRAIN;
        if (flush_q && (cnt_q == '0)) flush_clr = 1'b1;
      end
      ST_DRAIN: begin
        if (dram_ready) begin
          if (burst_last) begin
            st_d      = ST_COLLECT;
            cnt_d     = '0;
            rd_d      = '0;
            flush_clr = 1'b1;
          end else begin
            rd_d = rd_q + IDX_W'(1);
          end
        end
      end
      default: st_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_COLLECT;
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
    end
  end

  AST_CNT_BOUND : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_LINES)) else $error("held count overflow"); // R10
  AST_DRAIN_NONEMPTY : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN) |-> (cnt_q != '0)) else $error("empty burst"); // R2
  AST_RD_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DRAIN) && !dram_ready) |=> ((st_q == ST_DRAIN) && $stable(rd_q)))
    else $error("burst pointer moved without handshake"); // R3

endmodule

// File: rtl/wr_gather.sv
module wr_gather #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int MAX_LINES  = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    cfg_we,
  input  logic [$clog2(MAX_LINES)-1:0]            cfg_limit,
  input  logic                                    cfg_flush,
  output logic [$clog2(MAX_LINES)-1:0]            limit_rd,
  output logic                                    flush_rd,
  input  logic                                    host_valid,
  output logic                                    host_ready,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    host_line,
  input  logic [DATA_W-1:0]                       host_data,
  output logic                                    dram_valid,
  input  logic                                    dram_ready,
  output logic [ADDR_W-1:0]                       dram_addr,
  output logic [DATA_W-1:0]                       dram_data,
  output logic                                    dram_last
);

  localparam int LIM_W  = $clog2(MAX_LINES);
  localparam int IDX_W  = $clog2(MAX_LINES);
  localparam int CNT_W  = $clog2(MAX_LINES + 1);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam int ENT_W  = LINE_W + DATA_W;

  logic [LIM_W-1:0] limit_q;
  logic             flush_q, flush_clr;
  logic             buf_we, drain_act, bypass_act, burst_last;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [ENT_W-1:0] rd_ent;
  logic [LINE_W-1:0] out_line;

  wr_gather_cfg #(.LIM_W(LIM_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_limit (cfg_limit),
    .cfg_flush (cfg_flush),
    .flush_clr (flush_clr),
    .limit_q   (limit_q),
    .flush_q   (flush_q)
  );

  wr_gather_fsm #(
    .MAX_LINES (MAX_LINES),
    .LIM_W     (LIM_W),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .limit_q    (limit_q),
    .flush_q    (flush_q),
    .host_valid (host_valid),
    .dram_ready (dram_ready),
    .host_ready (host_ready),
    .buf_we     (buf_we),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .drain_act  (drain_act),
    .bypass_act (bypass_act),
    .burst_last (burst_last),
    .flush_clr  (flush_clr)
  );

  wr_gather_buf #(
    .DEPTH (MAX_LINES),
    .ENT_W (ENT_W),
    .IDX_W (IDX_W)
  ) u_buf (
    .clk    (clk),
    .wr_en  (buf_we),
    .wr_idx (wr_idx),
    .wr_ent ({host_line, host_data}),
    .rd_idx (rd_idx),
    .rd_ent (rd_ent)
  );

  assign limit_rd   = limit_q;
  assign flush_rd   = flush_q;
  assign out_line   = drain_act ? rd_ent[ENT_W-1:DATA_W] : host_line;
  assign dram_addr  = {out_line, {OFS_W{1'b0}}};
  assign dram_data  = drain_act ? rd_ent[DATA_W-1:0] : host_data;
  assign dram_valid = drain_act | (bypass_act & host_valid);
  assign dram_last  = drain_act ? burst_last : bypass_act;

  AST_HOLD_STABLE : assert property (@(posedge clk) disable iff (!rst_n)
    (drain_act && !dram_ready) |=> (dram_valid && $stable(dram_addr) && $stable(dram_data)))
    else $error("burst beat changed while stalled"); // R3
  AST_NO_TAKE_DRAIN : assert property (@(posedge clk) disable iff (!rst_n)
    drain_act |-> !host_ready) else $error("host accepted during burst"); // R9
  AST_FLUSH_STAYS : assert property (@(posedge clk) disable iff (!rst_n)
    (flush_rd && drain_act && !(dram_ready && dram_last)) |=> flush_rd)
    else $error("flush cleared early"); // R8
  AST_LAST_VALID : assert property (@(posedge clk) disable iff (!rst_n)
    dram_last |-> dram_valid || !host_valid) else $error("last without beat"); // R5

endmodule

// File: tb/wr_gather_bench.sv
module wr_gather_bench;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = AW - 6;

  logic          clk;
  logic          rst_n;
  logic          cfg_we, cfg_flush;
  logic [4:0]    cfg_limit, limit_rd;
  logic          flush_rd;
  logic          host_valid, host_ready;
  logic [LW-1:0] host_line;
  logic [DW-1:0] host_data;
  logic          dram_valid, dram_ready, dram_last;
  logic [AW-1:0] dram_addr;
  logic [DW-1:0] dram_data;

  int total = 0;
  int bad   = 0;
  int wd    = 0;
  bit done  = 0;

  wr_gather u_wr_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_limit  (cfg_limit),
    .cfg_flush  (cfg_flush),
    .limit_rd   (limit_rd),
    .flush_rd   (flush_rd),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_line  (host_line),
    .host_data  (host_data),
    .dram_valid (dram_valid),
    .dram_ready (dram_ready),
    .dram_addr  (dram_addr),
    .dram_data  (dram_data),
    .dram_last  (dram_last)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Behavioural reference state
  logic [LW-1:0] m_line [$];
  logic [DW-1:0] m_data [$];
  int m_lim;
  bit m_fl, m_dr;

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_flush = 0; cfg_limit = '0;
    host_valid = 0; host_line = '0; host_data = '0; dram_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(limit_rd == 5'd31, "R1", "limit_rd", 64'(limit_rd), 64'd31);
    chk(flush_rd == 1'b0,  "R1", "flush_rd", 64'(flush_rd), 64'd0);
    chk(dram_valid == 1'b0, "R1", "dram_valid", 64'(dram_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    m_lim = 31; m_fl = 0; m_dr = 0;

    for (int c = 0; c < 2000; c++) begin
      string tag;
      bit bp, e_dv, e_hr, e_l, acc, clr;
      logic [AW-1:0] e_a;
      logic [DW-1:0] e_d;
      int tgt;
      @(negedge clk);
      cfg_we = 0; cfg_flush = 0;
      host_line = LW'($urandom);
      host_data = $urandom;
      if (c < 60) begin
        tag = "R6"; host_valid = $urandom % 2; dram_ready = ($urandom % 4) != 0;
      end else if (c < 200) begin
        tag = "R2"; host_valid = ($urandom % 8) != 0; dram_ready = ($urandom % 8) != 0;
        if (c == 60) begin cfg_we = 1; cfg_limit = 5'd28; end
      end else if (c < 400) begin
        tag = "R10"; host_valid = ($urandom % 4) != 0; dram_ready = $urandom % 2;
        if (c == 200) begin cfg_we = 1; cfg_limit = 5'd0; end
      end else if (c < 441) begin
        // R7: partial gather of 6 lines under a 12-line limit, then flush
        tag = "R7"; host_valid = (c > 400 && c < 407); dram_ready = $urandom % 2;
        if (c == 400) begin cfg_we = 1; cfg_limit = 5'd20; dram_ready = 1; end
        if (c == 407) begin cfg_we = 1; cfg_limit = 5'd20; cfg_flush = 1; end
      end else if (c < 451) begin
        tag = "R8"; host_valid = 0; dram_ready = 1;
        if (c == 441) begin cfg_we = 1; cfg_limit = 5'd20; cfg_flush = 1; end
      end else begin
        tag = "R3"; host_valid = $urandom % 2; dram_ready = ($urandom % 3) != 0;
        if (($urandom % 40) == 0) begin
          cfg_we = 1;
          cfg_limit = (($urandom % 3) == 0) ? 5'd31 : 5'(24 + $urandom % 8);
          cfg_flush = ($urandom % 3) == 0;
        end
      end
      #1;
      tgt = 32 - m_lim;
      bp = (m_lim == 31) && !m_dr && (m_line.size() == 0) && !m_fl;
      e_a = '0; e_d = '0; e_l = 0;
      if (m_dr) begin
        e_dv = 1; e_hr = 0;
        e_a = {m_line[0], 6'b0}; e_d = m_data[0]; e_l = (m_line.size() == 1);
      end else if (bp) begin
        e_dv = host_valid; e_hr = dram_ready;
        e_a = {host_line, 6'b0}; e_d = host_data; e_l = 1;
      end else begin
        e_dv = 0; e_hr = !m_fl && (m_line.size() < tgt);
      end
      chk(host_ready == e_hr, "R9", "host_ready", 64'(host_ready), 64'(e_hr));
      chk(dram_valid == e_dv, tag, "dram_valid", 64'(dram_valid), 64'(e_dv));
      chk(limit_rd == 5'(m_lim), "R1", "limit_rd", 64'(limit_rd), 64'(m_lim));
      chk(flush_rd == m_fl, "R8", "flush_rd", 64'(flush_rd), 64'(m_fl));
      if (e_dv) begin
        chk(dram_addr == e_a, "R4", "dram_addr", 64'(dram_addr), 64'(e_a));
        chk(dram_data == e_d, "R4", "dram_data", 64'(dram_data), 64'(e_d));
        chk(dram_last == e_l, "R5", "dram_last", 64'(dram_last), 64'(e_l));
      end
      // advance the model as the coming rising edge will
      acc = host_valid && e_hr && !bp;
      clr = 0;
      if (m_dr) begin
        if (dram_ready) begin
          void'(m_line.pop_front());
          void'(m_data.pop_front());
          if (m_line.size() == 0) begin m_dr = 0; clr = 1; end
        end
      end else begin
        if (acc) begin m_line.push_back(host_line); m_data.push_back(host_data); end
        if (m_line.size() > 0 && (m_line.size() >= tgt || m_fl)) m_dr = 1;
        if (m_fl && m_line.size() == 0) clr = 1;
      end
      if (clr) m_fl = 0;
      if (cfg_we) begin
        m_lim = cfg_limit;
        if (cfg_flush) m_fl = 1;
      end
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule